// File: doc/BRIEF.md
# Synchronous FIFO with Serially Programmable Threshold Flags

This block is a single-clock FIFO. Next to the usual empty and full indications it drives two active-low early-warning flags. The almost-empty flag compares the occupancy with an offset `n`. The almost-full flag compares the occupancy with an offset `m`, counted back from the depth `D`.

A synchronous master reset sets the start-up state. While reset is held low, a two-bit select picks one of four default thresholds. That default is written into both offset registers. In the same reset window a mode input chooses between standard read timing and first-word-fall-through read timing.

After reset, software-free hardware can retune both thresholds through a three-wire serial port. The port carries a slow serial clock, a data bit and an enable. The serial lines are synchronised into the FIFO clock domain. Their clock must stay in each phase for at least three FIFO clock cycles. `DEPTH` must be a power of two.

Top module: `pflag_fifo`

## Requirements
- R1: After master reset the block shows `empty`=1, `full`=0, `ae_n`=0 and `af_n`=1.
- R2: The value of `cfg_sel` during reset loads both offsets as follows: 0 gives 127, 1 gives 1023, 2 gives 4095 and 3 gives 16383. Any value above D−1 is clipped to D−1.
- R3: `ae_n` is low exactly when the occupancy is at most `n`. It follows the occupancy one clock edge after the occupancy changes.
- R4: `af_n` is low exactly when the occupancy is at least D−`m`. It follows the occupancy one clock edge after the occupancy changes.
- R5: In standard mode, an accepted `rd_en` puts the oldest word on `rd_data` at the next clock edge. `rd_data` does not change without a read, and words leave in write order.
- R6: In first-word-fall-through mode, a word written into an empty FIFO appears on `rd_data` two edges after its write, without any read. `empty` covers the output stage. Each accepted `rd_en` moves the next word onto `rd_data`.
- R7: `cfg_sel` and `cfg_fwft` are taken only while `rst_n` is low. Changing them afterwards has no effect.
- R8: A bit enters on a rising `ser_clk` only while `ser_en` is 1, least significant bit first. The first log2(D) bits form `n` and the next log2(D) bits form `m`. Each offset takes effect as soon as its last bit is captured.
- R9: After both offsets are loaded, the bit counter wraps. A further serial sequence again rewrites `n` first and then `m`.
- R10: A write while `full` and a read while `empty` are ignored. They change neither the occupancy nor the stored data.
- R11: `full` is 1 when D words are held. `empty` is 1 when no word is readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO clock |
| rst_n | input | 1 | Synchronous master reset, active low |
| cfg_sel | input | 2 | Default threshold select, sampled during reset |
| cfg_fwft | input | 1 | 1 selects first-word-fall-through timing, sampled during reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Read data |
| empty | output | 1 | No readable word |
| full | output | 1 | D words held |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |
| ser_clk | input | 1 | Serial programming clock |
| ser_din | input | 1 | Serial programming data |
| ser_en | input | 1 | Serial programming enable |

## Verification
The results fall due at different edges, and the bench samples each one at the falling clock edge after that edge:
- `empty` and `full` follow a write or read at the same rising edge.
- `ae_n` and `af_n` follow one edge later, so every fill step waits one extra cycle before it checks a flag.
- Standard-mode read data is due one edge after the strobe.
- A fall-through first word is due two edges after its write. The bench checks that `empty` is still high in the cycle in between.
- A serial bit is captured three FIFO edges after the serial clock rises, and the flags follow one edge later. The serial task therefore holds each phase for several cycles before any flag is checked.

// File: rtl/pflag_fifo.sv
module pflag_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_sel,
  input  logic          cfg_fwft,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic          ae_n,
  output logic          af_n,
  input  logic          ser_clk,
  input  logic          ser_din,
  input  logic          ser_en
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int OW = AW;
  localparam int BW = $clog2(2 * OW);

  function automatic logic [OW-1:0] dflt(input logic [1:0] s);
    int v;
    case (s)
      2'd0:    v = 127;
      2'd1:    v = 1023;
      2'd2:    v = 4095;
      default: v = 16383;
    endcase
    if (v > DEPTH - 1) v = DEPTH - 1;
    return OW'(v);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] mcnt, total;
  logic          ovld, fwft_q;
  logic [OW-1:0] n_off, m_off, shreg;
  logic [BW-1:0] bcnt;
  logic [2:0]    sclk_q;
  logic [1:0]    sdin_q, sen_q;
  logic          wr_ok, rd_ok, pop, sbit;
  logic [OW-1:0] shnext;

  assign total  = mcnt + CW'(ovld);
  assign full   = (total == CW'(DEPTH));
  assign empty  = fwft_q ? !ovld : (mcnt == '0);
  assign wr_ok  = wr_en && !full;
  assign rd_ok  = rd_en && (fwft_q ? ovld : (mcnt != '0));
  assign pop    = fwft_q ? ((mcnt != '0) && (!ovld || rd_ok)) : rd_ok;
  assign sbit   = sclk_q[1] && !sclk_q[2] && sen_q[1];
  assign shnext = {sdin_q[1], shreg[OW-1:1]};

  always_ff @(posedge clk)
    if (wr_ok) mem[wptr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      mcnt    <= '0;
      ovld    <= 1'b0;
      rd_data <= '0;
      fwft_q  <= cfg_fwft;
      ae_n    <= 1'b0;
      af_n    <= 1'b1;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (pop) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr];
      end
      mcnt <= mcnt + CW'(wr_ok) - CW'(pop);
      if (fwft_q) ovld <= pop | (ovld & ~rd_ok);
      ae_n <= (total > CW'(n_off));
      af_n <= (total < CW'(DEPTH) - CW'(m_off));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= '0;
      sdin_q <= '0;
      sen_q  <= '0;
      bcnt   <= '0;
      shreg  <= '0;
      n_off  <= dflt(cfg_sel);
      m_off  <= dflt(cfg_sel);
    end else begin
      sclk_q <= {sclk_q[1:0], ser_clk};
      sdin_q <= {sdin_q[0], ser_din};
      sen_q  <= {sen_q[0], ser_en};
      if (sbit) begin
        shreg <= shnext;
        if (bcnt == BW'(OW - 1)) n_off <= shnext;
        if (bcnt == BW'(2 * OW - 1)) begin
          m_off <= shnext;
          bcnt  <= '0;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic rd_en,
  input logic empty,
  input logic full,
  input logic ae_n,
  input logic af_n
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (empty && !full && !ae_n && af_n)); // R1

  AST_EMPTY_AE: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && $past(empty)) |-> !ae_n); // R3

  AST_FULL_AF: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(full)) |-> !af_n); // R4

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full); // R10

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full)); // R11
endmodule

bind pflag_fifo pflag_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .empty(empty), .full(full), .ae_n(ae_n), .af_n(af_n)
);

// File: tb/pflag_fifo_tb.sv
module pflag_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DEPTH = 1024;
  localparam int OW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic cfg_fwft = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic empty, full, ae_n, af_n;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pflag_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_fwft(cfg_fwft),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .full(full), .ae_n(ae_n), .af_n(af_n),
    .ser_clk(ser_clk), .ser_din(ser_din), .ser_en(ser_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] sel, input logic fw);
    rst_n = 1'b0; cfg_sel = sel; cfg_fwft = fw;
    wr_en = 1'b0; rd_en = 1'b0; ser_en = 1'b0; ser_clk = 1'b0;
    tick(3);
    rst_n = 1'b1; cfg_sel = ~sel; cfg_fwft = ~fw;
    tick(1);
  endtask

  task automatic push(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_data = DW'(base + i);
      tick(1);
    end
    wr_en = 1'b0;
    tick(1);
  endtask

  task automatic pop_std(input int n, input int base, input string tag);
    for (int i = 0; i < n; i++) begin
      rd_en = 1'b1;
      tick(1);
      chk(tag, rd_data, (base + i) & 255);
    end
    rd_en = 1'b0;
    tick(1);
  endtask

  task automatic ser_bit(input logic b, input logic en);
    ser_din = b; ser_en = en;
    tick(4);
    ser_clk = 1'b1;
    tick(4);
    ser_clk = 1'b0; ser_en = 1'b0;
    tick(2);
  endtask

  task automatic ser_word(input int v);
    for (int i = 0; i < OW; i++) begin
      ser_bit(~v[i], 1'b0);
      ser_bit(v[i], 1'b1);
    end
  endtask

  task automatic t_reset;
    do_reset(2'd0, 1'b0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 ae_n", ae_n, 0);
    chk("R1 af_n", af_n, 1);
  endtask

  task automatic t_sel0;
    do_reset(2'd0, 1'b0);
    push(127, 0);
    chk("R3 ae_n at 127", ae_n, 0);
    push(1, 127);
    chk("R3 ae_n at 128", ae_n, 1);
    push(768, 128);
    chk("R4 af_n at 896", af_n, 1);
    push(1, 896);
    chk("R4 af_n at 897", af_n, 0);
    push(127, 897);
    chk("R11 full at D", full, 1);
    push(1, 200);
    chk("R10 full after ignored write", full, 1);
    pop_std(1024, 0, "R5/R10 order");
    chk("R11 empty after drain", empty, 1);
    chk("R3 ae_n after drain", ae_n, 0);
    rd_en = 1'b1; tick(1); rd_en = 1'b0; tick(1);
    chk("R10 empty after read of empty", empty, 1);
    push(1, 77);
    chk("R5 R7 no fall-through in standard mode", rd_data, 255);
    chk("R10 one word after ignored read", empty, 0);
    pop_std(1, 77, "R10 word after ignored read");
    chk("R10 empty again", empty, 1);
  endtask

  task automatic t_sel_other;
    do_reset(2'd1, 1'b0);
    push(1, 0);
    chk("R2 sel1 af_n at 1", af_n, 0);
    push(1022, 1);
    chk("R2 sel1 ae_n at 1023", ae_n, 0);
    push(1, 5);
    chk("R2 sel1 ae_n at 1024", ae_n, 1);
    for (int s = 2; s < 4; s++) begin
      do_reset(2'(s), 1'b0);
      chk("R2 clipped af_n at 0", af_n, 1);
      push(1, 0);
      chk("R2 clipped af_n at 1", af_n, 0);
    end
  endtask

  task automatic t_fwft;
    do_reset(2'd0, 1'b1);
    chk("R6 empty at start", empty, 1);
    wr_en = 1'b1; wr_data = 8'h5A;
    tick(1);
    wr_en = 1'b0;
    chk("R6 empty one edge after write", empty, 1);
    tick(1);
    chk("R6 R7 empty cleared", empty, 0);
    chk("R6 R7 first word shown", rd_data, 8'h5A);
    push(2, 8'h10);
    rd_en = 1'b1;
    tick(1);
    chk("R6 second word", rd_data, 8'h10);
    tick(1);
    chk("R6 third word", rd_data, 8'h11);
    tick(1);
    rd_en = 1'b0;
    chk("R6 empty after last read", empty, 1);
  endtask

  task automatic t_serial;
    do_reset(2'd0, 1'b0);
    ser_word(5);
    ser_word(10);
    push(5, 0);
    chk("R8 ae_n at n", ae_n, 0);
    push(1, 5);
    chk("R8 ae_n above n", ae_n, 1);
    push(1007, 6);
    chk("R8 af_n at 1013", af_n, 1);
    push(1, 9);
    chk("R8 af_n at 1014", af_n, 0);
    ser_word(1020);
    chk("R9 new n applied", ae_n, 0);
    ser_word(3);
    chk("R9 new m applied", af_n, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sel0();
    t_sel_other();
    t_fwft();
    t_serial();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule